// File: doc/BRIEF.md
# Configuration Space Shadow with Writable-Bit Overlay

This block keeps a copy of a PCIe-style configuration space, up to 4 KB, in a dword-wide block RAM and answers the host's configuration reads and writes from that copy. The base image is loaded through a separate initialization port and is never changed by the host. Writable bits live in a small overlay store instead. An elaboration-time table lists the overlaid dwords, each with its own writable-bit mask. By default the table holds Command/Status, the Cache Line Size / Latency Timer / BIST dword, two BARs whose masks follow their sizes, the interrupt line and an MSI control word.

A request carries a function number, a dword address (bits [11:2] of the byte address), four byte enables and write data. Reads return the base word with the masked bits taken from the overlay. Writes change only the masked, byte-enabled bits of the overlay entry, as a read-modify-write. Requests for a non-zero function, or for a configured dword window, are not served from the shadow. They end with a pass-through flag so that a hardware path can take them. Only one request is in flight at a time. Every request completes with a one-cycle pulse exactly three cycles after it is accepted.

Top module: `cfg_shadow_ovl`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, `rsp_valid`, `wr_ack` and `pt_flag` are 0, and every overlay entry is zero, so an overlaid dword reads as its base word with the masked bits cleared.
- R2: A served read returns `(base & ~mask) | (overlay & mask)`, and a dword with no table entry returns its base word unchanged.
- R3: A served write changes only bits that are set in the dword's mask, and only in the overlay. The bits outside the mask keep reading from the base image.
- R4: Byte enable k covers data bits [8k+7:8k], and byte lane 0 is the lowest byte address. Bytes whose enable is 0 keep their overlay value.
- R5: A write to a dword with no table entry changes nothing that can be read back.
- R6: The default table holds these masks: dword 1 0x00000547, dword 3 0x4000FFFF, dword 4 0xFFFFF000, dword 5 0xFFFF0000, dword 15 0x000000FF and dword 20 0x00710000.
- R7: A request whose `req_func` is not 0 ends with `pt_flag` and without `rsp_valid` or `wr_ack`, and a write of this kind changes no shadow state.
- R8: A function-0 request whose dword address lies in the window from `PASS_LO` to `PASS_HI`, inclusive, ends with `pt_flag` and changes no shadow state.
- R9: A function-0 request at or beyond `SPACE_BYTES/4` dwords that is outside the window is served. A read returns 0, and a write is acknowledged and dropped.
- R10: The completion pulse lasts one cycle and comes in the third cycle after the accepting edge. `req_ready` is 0 from the accepting edge until the end of that pulse.
- R11: The initialization port writes the base image at any time. When it writes the dword that a host read is sampling in the same cycle, the read returns the old value, and later reads return the new value, merged with the overlay.
- R12: A served read ends with `rsp_valid` and a served write ends with `wr_ack`. At most one of `rsp_valid`, `wr_ack` and `pt_flag` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_func | input | 3 | Target function number |
| req_addr | input | 10 | Dword address |
| req_be | input | 4 | Byte enables, bit k selects lane k |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data |
| wr_ack | output | 1 | Write completion pulse |
| pt_flag | output | 1 | Request not served by the shadow |
| init_we | input | 1 | Base image write strobe |
| init_addr | input | 10 | Base image dword address |
| init_wdata | input | 32 | Base image data |

## Verification
Two functions can meet in one cycle: an initialization write to the base RAM, and the RAM read of a host request. The bench issues a host read of a plain dword. In the next cycle, while the RAM read is in progress, it drives an initialization write of new data to the same dword. The scoreboard expects the old word in that response and the new word in the next read. A second collision hits an overlaid dword, where the merged result must combine the new base bits with the overlay bits that were already there.

// File: rtl/cfgsh_pkg.sv
// Shared definitions for the configuration space shadow.
// Assumes a fixed 10-bit dword address (4 KB maximum space).
package cfgsh_pkg;
    localparam int CFG_AW = 10;
    localparam int CFG_DW = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_MERGE,
        ST_RESPOND
    } cfgsh_state_e;
endpackage

// File: rtl/cfgsh_base_ram.sv
// Base image storage: one write port (initialization), one read port (host).
// Read is registered and read-first: a same-cycle write to the read
// address returns the old word. Contents are not cleared by reset.
module cfgsh_base_ram #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [cfgsh_pkg::CFG_DW-1:0] wdata,
    input  logic [AW-1:0]             raddr,
    output logic [cfgsh_pkg::CFG_DW-1:0] rdata
);
    logic [cfgsh_pkg::CFG_DW-1:0] mem [DEPTH];

    // Write port and registered read-first read port
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/cfgsh_ovl_lookup.sv
// Maps a dword address to an overlay index and writable-bit mask.
// Assumes the table addresses are distinct; a miss returns hit=0, mask=0.
module cfgsh_ovl_lookup #(
    parameter int NUM_OVL = 6,
    parameter logic [NUM_OVL-1:0][cfgsh_pkg::CFG_AW-1:0] OVL_DWORD = '0,
    parameter logic [NUM_OVL-1:0][cfgsh_pkg::CFG_DW-1:0] OVL_MASK  = '0,
    localparam int IW = (NUM_OVL > 1) ? $clog2(NUM_OVL) : 1
) (
    input  logic [cfgsh_pkg::CFG_AW-1:0] addr,
    output logic                         hit,
    output logic [IW-1:0]                idx,
    output logic [cfgsh_pkg::CFG_DW-1:0] mask
);
    logic [NUM_OVL-1:0] match;

    genvar g;
    generate
        for (g = 0; g < NUM_OVL; g++) begin : g_cmp
            assign match[g] = (addr == OVL_DWORD[g]);
        end
    endgenerate

    // Encode the matching entry into index and mask
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        mask = '0;
        for (int i = 0; i < NUM_OVL; i++) begin
            if (match[i]) begin
                hit  = 1'b1;
                idx  = IW'(i);
                mask = OVL_MASK[i];
            end
        end
    end
endmodule

// File: rtl/cfgsh_ovl_store.sv
// Overlay entries held in flops, one per table row.
// Cleared to zero by synchronous active-low reset; combinational read.
module cfgsh_ovl_store #(
    parameter int NUM_OVL = 6,
    localparam int IW = (NUM_OVL > 1) ? $clog2(NUM_OVL) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IW-1:0]                widx,
    input  logic [cfgsh_pkg::CFG_DW-1:0] wdata,
    input  logic [IW-1:0]                ridx,
    output logic [cfgsh_pkg::CFG_DW-1:0] rdata
);
    logic [cfgsh_pkg::CFG_DW-1:0] ent [NUM_OVL];

    genvar g;
    generate
        for (g = 0; g < NUM_OVL; g++) begin : g_ent
            // Hold one overlay word, cleared on reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent[g] <= '0;
                end else if (we && (widx == IW'(g))) begin
                    ent[g] <= wdata;
                end
            end
        end
    endgenerate

    // Select the entry for the current lookup
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_OVL; i++) begin
            if (ridx == IW'(i)) rdata = ent[i];
        end
    end
endmodule

// File: rtl/cfg_shadow_ovl.sv
// Configuration space shadow: base RAM plus masked overlay for writable bits.
// One request at a time; completion pulse three cycles after acceptance.
// Assumes SPACE_BYTES is a power of two from 256 to 4096 and that the
// overlay table addresses are distinct.
module cfg_shadow_ovl #(
    parameter int SPACE_BYTES = 4096,
    parameter int NUM_OVL     = 6,
    parameter logic [NUM_OVL-1:0][9:0] OVL_DWORD =
        {10'd20, 10'd15, 10'd5, 10'd4, 10'd3, 10'd1},
    parameter logic [NUM_OVL-1:0][31:0] OVL_MASK =
        {32'h0071_0000, 32'h0000_00FF, 32'hFFFF_0000,
         32'hFFFF_F000, 32'h4000_FFFF, 32'h0000_0547},
    parameter logic [9:0] PASS_LO = 10'h3C0,
    parameter logic [9:0] PASS_HI = 10'h3FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [2:0]  req_func,
    input  logic [9:0]  req_addr,
    input  logic [3:0]  req_be,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        wr_ack,
    output logic        pt_flag,
    input  logic        init_we,
    input  logic [9:0]  init_addr,
    input  logic [31:0] init_wdata
);
    import cfgsh_pkg::*;

    localparam int DEPTH  = SPACE_BYTES / 4;
    localparam int RAM_AW = $clog2(DEPTH);
    localparam int IW     = (NUM_OVL > 1) ? $clog2(NUM_OVL) : 1;

    cfgsh_state_e st;
    logic         r_write, r_pt, r_oob;
    logic [9:0]   r_addr;
    logic [3:0]   r_be;
    logic [31:0]  r_wdata, rdata_q;
    logic         accept, pt_now, oob_now;
    logic         lk_hit;
    logic [IW-1:0] lk_idx;
    logic [31:0]  lk_mask, base_rd, ovl_rd, byte_mask, wmask, eff_mask;
    logic [31:0]  ovl_new, merged;
    logic         ovl_we, init_ok;

    assign accept  = req_valid && (st == ST_IDLE);
    assign pt_now  = (req_func != 3'd0) || ((req_addr >= PASS_LO) && (req_addr <= PASS_HI));
    assign oob_now = (32'(req_addr) >= DEPTH);
    assign init_ok = init_we && (32'(init_addr) < DEPTH);

    cfgsh_base_ram #(.DEPTH(DEPTH)) u_base (
        .clk   (clk),
        .we    (init_ok),
        .waddr (init_addr[RAM_AW-1:0]),
        .wdata (init_wdata),
        .raddr (r_addr[RAM_AW-1:0]),
        .rdata (base_rd)
    );

    cfgsh_ovl_lookup #(
        .NUM_OVL   (NUM_OVL),
        .OVL_DWORD (OVL_DWORD),
        .OVL_MASK  (OVL_MASK)
    ) u_lookup (
        .addr (r_addr),
        .hit  (lk_hit),
        .idx  (lk_idx),
        .mask (lk_mask)
    );

    cfgsh_ovl_store #(.NUM_OVL(NUM_OVL)) u_ovl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ovl_we),
        .widx  (lk_idx),
        .wdata (ovl_new),
        .ridx  (lk_idx),
        .rdata (ovl_rd)
    );

    // Expand byte enables to bit lanes and build merge / write masks
    always_comb begin
        for (int b = 0; b < 4; b++) begin
            byte_mask[8*b +: 8] = {8{r_be[b]}};
        end
        eff_mask = lk_hit ? lk_mask : 32'h0;
        wmask    = eff_mask & byte_mask;
        ovl_new  = (ovl_rd & ~wmask) | (r_wdata & wmask);
        merged   = (base_rd & ~eff_mask) | (ovl_rd & eff_mask);
    end

    assign ovl_we = (st == ST_MERGE) && r_write && !r_pt && !r_oob && lk_hit;

    // Access state machine: capture, RAM read, merge, respond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            r_write <= 1'b0;
            r_pt    <= 1'b0;
            r_oob   <= 1'b0;
            r_addr  <= '0;
            r_be    <= '0;
            r_wdata <= '0;
            rdata_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    r_write <= req_write;
                    r_pt    <= pt_now;
                    r_oob   <= oob_now;
                    r_addr  <= req_addr;
                    r_be    <= req_be;
                    r_wdata <= req_wdata;
                    st      <= ST_LOOKUP;
                end
                ST_LOOKUP: st <= ST_MERGE;
                ST_MERGE: begin
                    rdata_q <= (r_pt || r_oob || r_write) ? 32'h0 : merged;
                    st      <= ST_RESPOND;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign rsp_valid = (st == ST_RESPOND) && !r_write && !r_pt;
    assign wr_ack    = (st == ST_RESPOND) && r_write && !r_pt;
    assign pt_flag   = (st == ST_RESPOND) && r_pt;
    assign rsp_rdata = rdata_q;

    // R10
    resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##3 (rsp_valid || wr_ack || pt_flag));

    // R12
    single_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, wr_ack, pt_flag}));

    // R7
    other_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_func != 3'd0)) |-> ##3 pt_flag);

    // R8
    pass_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_addr >= PASS_LO) && (req_addr <= PASS_HI)) |-> ##3 pt_flag);

    // R9
    oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && oob_now && !pt_now && !req_write) |-> ##3 (rsp_valid && (rsp_rdata == 32'h0)));
endmodule

// File: tb/cfg_shadow_ovl_tb_top.sv
module cfg_shadow_ovl_tb_top;
    localparam int SPACE   = 2048;
    localparam int NWORDS  = SPACE / 4;
    localparam logic [9:0] P_LO = 10'h100;
    localparam logic [9:0] P_HI = 10'h10F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_func = '0;
    logic [9:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        init_we = 1'b0;
    logic [9:0]  init_addr = '0;
    logic [31:0] init_wdata = '0;
    logic        req_ready, rsp_valid, wr_ack, pt_flag;
    logic [31:0] rsp_rdata;

    always #10 clk = ~clk;  // 50 MHz

    cfg_shadow_ovl #(.SPACE_BYTES(SPACE), .PASS_LO(P_LO), .PASS_HI(P_HI)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_func(req_func), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .wr_ack(wr_ack), .pt_flag(pt_flag),
        .init_we(init_we), .init_addr(init_addr), .init_wdata(init_wdata)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [31:0] base_m [1024];
    logic [31:0] ovl_m  [1024];

    // kind: 0 read data, 1 write ack, 2 pass-through
    int          q_kind [$];
    logic [31:0] q_data [$];
    int          q_cyc  [$];
    string       q_req  [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input int a);
        case (a)
            1:  return 32'h0000_0547;
            3:  return 32'h4000_FFFF;
            4:  return 32'hFFFF_F000;
            5:  return 32'hFFFF_0000;
            15: return 32'h0000_00FF;
            20: return 32'h0071_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] be_bits(input logic [3:0] be);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
        return m;
    endfunction

    // Driver: wait idle, push expected item, present request for one edge
    task automatic issue(input bit wr, input logic [2:0] f, input int a,
                         input logic [3:0] be, input logic [31:0] wd, input string req);
        bit pt;
        logic [31:0] m, wm, exp;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        pt = (f != 3'd0) || (a >= P_LO && a <= P_HI);
        m  = mask_of(a);
        exp = 32'h0;
        if (!pt && !wr && a < NWORDS) exp = (base_m[a] & ~m) | (ovl_m[a] & m);
        if (!pt && wr && a < NWORDS) begin
            wm = m & be_bits(be);
            ovl_m[a] = (ovl_m[a] & ~wm) | (wd & wm);
        end
        q_kind.push_back(pt ? 2 : (wr ? 1 : 0));
        q_data.push_back(exp);
        q_cyc.push_back(cyc + 3);
        q_req.push_back(req);
        req_valid = 1'b1; req_write = wr; req_func = f;
        req_addr = 10'(a); req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic init_word(input int a, input logic [31:0] d);
        @(negedge clk);
        init_we = 1'b1; init_addr = 10'(a); init_wdata = d;
        @(negedge clk);
        init_we = 1'b0;
        base_m[a] = d;
    endtask

    // Monitor: pop expected items as completions appear
    always @(negedge clk) begin
        if (rst_n && (rsp_valid || wr_ack || pt_flag)) begin
            if (q_kind.size() == 0) begin
                check(1'b0, "R12", "unexpected completion", {29'b0, rsp_valid, wr_ack, pt_flag}, 32'h0);
            end else begin
                int k; logic [31:0] d; int c; string r;
                k = q_kind.pop_front(); d = q_data.pop_front();
                c = q_cyc.pop_front();  r = q_req.pop_front();
                check((k == 0) ? rsp_valid : ((k == 1) ? wr_ack : pt_flag), r, "completion kind",
                      {29'b0, rsp_valid, wr_ack, pt_flag}, 32'(k));
                if (k == 0) check(rsp_rdata == d, r, "read data", rsp_rdata, d);
                check(cyc == c, "R10", "completion cycle", 32'(cyc), 32'(c));
                check(!req_ready, "R10", "ready low during completion", {31'b0, req_ready}, 32'h0);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            base_m[i] = 32'h0;
            ovl_m[i]  = 32'h0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(req_ready == 1'b1, "R1", "ready after reset", {31'b0, req_ready}, 32'h1);
        check({rsp_valid, wr_ack, pt_flag} == 3'b000, "R1", "completions idle after reset",
              {29'b0, rsp_valid, wr_ack, pt_flag}, 32'h0);
        for (int i = 0; i < NWORDS; i++) begin
            init_word(i, (32'h1000_0193 * i) ^ 32'hC3C3_5A5A);
        end
        // R1 / R6 overlay cleared: masked bits read as zero
        issue(0, 3'd0, 1, 4'hF, 32'h0, "R1");
        issue(0, 3'd0, 4, 4'hF, 32'h0, "R6");
        // R2 plain dword
        issue(0, 3'd0, 8, 4'hF, 32'h0, "R2");
        // R3 full write to command/status
        issue(1, 3'd0, 1, 4'hF, 32'hFFFF_FFFF, "R3");
        issue(0, 3'd0, 1, 4'hF, 32'h0, "R3");
        // R4 single byte lane
        issue(1, 3'd0, 3, 4'b0010, 32'h1234_5678, "R4");
        issue(0, 3'd0, 3, 4'hF, 32'h0, "R4");
        issue(1, 3'd0, 3, 4'b1001, 32'hFFFF_FFAA, "R4");
        issue(0, 3'd0, 3, 4'hF, 32'h0, "R4");
        // R6 BAR sizing and other table entries
        issue(1, 3'd0, 4, 4'hF, 32'hFFFF_FFFF, "R6");
        issue(0, 3'd0, 4, 4'hF, 32'h0, "R6");
        issue(1, 3'd0, 5, 4'b1100, 32'hABCD_1234, "R6");
        issue(0, 3'd0, 5, 4'hF, 32'h0, "R6");
        issue(1, 3'd0, 15, 4'hF, 32'h0000_0033, "R6");
        issue(0, 3'd0, 15, 4'hF, 32'h0, "R6");
        issue(1, 3'd0, 20, 4'hF, 32'hFFFF_FFFF, "R6");
        issue(0, 3'd0, 20, 4'hF, 32'h0, "R6");
        // R5 write to non-overlaid dword
        issue(1, 3'd0, 8, 4'hF, 32'hDEAD_BEEF, "R5");
        issue(0, 3'd0, 8, 4'hF, 32'h0, "R5");
        // R7 other function
        issue(0, 3'd3, 1, 4'hF, 32'h0, "R7");
        issue(1, 3'd3, 1, 4'hF, 32'h0, "R7");
        issue(0, 3'd0, 1, 4'hF, 32'h0, "R7");
        // R8 pass-through window
        issue(0, 3'd0, 10'h105, 4'hF, 32'h0, "R8");
        issue(1, 3'd0, 10'h100, 4'hF, 32'h0, "R8");
        issue(0, 3'd0, 10'h10F, 4'hF, 32'h0, "R8");
        // R9 beyond configured size
        issue(0, 3'd0, 600, 4'hF, 32'h0, "R9");
        issue(1, 3'd0, 513, 4'hF, 32'h0, "R9");
        issue(0, 3'd0, 1, 4'hF, 32'h0, "R9");
        // R11 collision: init write lands while host read samples the RAM
        issue(0, 3'd0, 8, 4'hF, 32'h0, "R11");
        init_we = 1'b1; init_addr = 10'd8; init_wdata = 32'h5555_AAAA;
        @(negedge clk);
        init_we = 1'b0;
        base_m[8] = 32'h5555_AAAA;
        issue(0, 3'd0, 8, 4'hF, 32'h0, "R11");
        issue(0, 3'd0, 1, 4'hF, 32'h0, "R11");
        init_we = 1'b1; init_addr = 10'd1; init_wdata = 32'h0F0F_0F0F;
        @(negedge clk);
        init_we = 1'b0;
        base_m[1] = 32'h0F0F_0F0F;
        issue(0, 3'd0, 1, 4'hF, 32'h0, "R11");
        // R2 / R3 mixed sweep
        begin
            logic [31:0] s;
            s = 32'h1234_ABCD;
            for (int n = 0; n < 60; n++) begin
                s = s * 32'd1664525 + 32'd1013904223;
                issue(s[31], 3'd0, int'(s[20:16]), s[11:8], s ^ 32'h9E37_79B9,
                      s[31] ? "R3" : "R2");
            end
        end
        while (q_kind.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(q_kind.size() == 0, "R12", "all completions seen", 32'(q_kind.size()), 32'h0);
        finish_run();
    end
endmodule